// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Command Register Bank

This block holds the digital state of a four-channel converter. Each channel has a staging (input) register and an output register. A 12-bit command word arrives from a serial front end together with a one-cycle execute strobe. The block decodes the word and acts on it. It can stage a code for one channel, stage a code and then update every output, copy all staged codes to the outputs, or broadcast one code to every channel. It can also enter or leave shutdown, drive a general-purpose output bit, and choose the phase mode used by the serial output logic.

Two pins act outside the command stream. An active-low load pin makes the output registers follow the staging registers for as long as it is held low. This pin is asynchronous to the clock and is synchronized first. An active-low clear pin zeroes every staging and output register at once, without waiting for a clock edge. The mode flags are not touched by the clear pin.

Top module: `quad_cmd_bank`

## Requirements
- R1: In a command word, bits [11:10] select the channel (0 to 3, which is channel i at `chan_code[i*8 +: 8]`), bits [9:8] are the control field and bits [7:0] are data. A word acts only on a rising edge where `cmd_exec` is high, and its effect is visible after that edge.
- R2: Control field 01 writes the data into the selected channel's staging register. While the load pin is inactive, no output register changes.
- R3: Control field 11 writes the data into the selected staging register. On the same edge it copies all four staging registers (including the new value) into the output registers.
- R4: Word bits [11:8] = 0100 copies all staging registers to the outputs and clears the shutdown flag.
- R5: Word bits [11:8] = 1000 writes the data byte into all four staging and all four output registers, and clears the shutdown flag.
- R6: Word bits [11:8] = 1100 sets the shutdown flag only when `pd_en` is high. When `pd_en` is low it has no effect.
- R7: Word bits [11:8] = 0010 drives `gpo` low, and 0110 drives it high.
- R8: Word bits [11:8] = 0000 changes no register and no output.
- R9: Word bits [11:8] = 1110 sets `phase_mode` to 1, and 1010 sets it to 0. Both also copy all staging registers to the outputs. Nothing else changes `phase_mode` except reset.
- R10: `load_n` passes through a two-flop synchronizer. The outputs start to follow the staging registers on the third rising edge after the pin falls. While it stays low, every staging update appears at the outputs on the same edge.
- R11: A low `clr_n` zeroes all staging and output registers without waiting for the clock, and leaves `shutdown`, `gpo` and `phase_mode` unchanged. A low `rst_n` zeroes every register and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 12 | Command word from the serial front end |
| cmd_exec | input | 1 | One-cycle strobe that executes `cmd_word` |
| load_n | input | 1 | Active-low load pin, asynchronous, level sensitive |
| clr_n | input | 1 | Active-low asynchronous clear of the staging and output registers |
| pd_en | input | 1 | Allows the shutdown command to take effect |
| chan_code | output | 32 | Four output codes, channel i at bits [i*8 +: 8] |
| shutdown | output | 1 | Shutdown flag |
| gpo | output | 1 | General-purpose output bit |
| phase_mode | output | 1 | Serial output phase mode |

## Verification
The hardest state to observe is a staging register that differs from its output register. No output shows it until a copy happens. The bench first creates such a mismatch with staging-only writes. It then exposes the staging contents in two ways: with a copy command, and by lowering the load pin. For the load pin, it checks the cycle before the synchronizer delay ends and the cycle after. The whole command space is swept both with the load pin inactive and with it held low, and with `pd_en` at each level. This shows that transparency and the shutdown gate interact correctly with every code.

// File: rtl/qcb_pkg.sv
package qcb_pkg;
    parameter int NCH = 4;
    parameter int DW  = 8;
    localparam int AW = $clog2(NCH);
    localparam int CW = AW + 2 + DW;

    typedef enum logic [1:0] {
        CTL_SPECIAL = 2'b00,
        CTL_STAGE   = 2'b01,
        CTL_MISC    = 2'b10,
        CTL_LOADUPD = 2'b11
    } ctl_e;

    typedef logic [DW-1:0] code_t;

    typedef struct packed {
        logic          stage_wr;
        logic [AW-1:0] sel;
        logic          copy_all;
        logic          bcast;
        logic          sd_set;
        logic          sd_clr;
        logic          gpo_wr;
        logic          gpo_val;
        logic          ph_wr;
        logic          ph_val;
        code_t         data;
    } act_t;

    typedef struct packed {
        code_t [NCH-1:0] inr;
        code_t [NCH-1:0] outr;
    } bank_t;

    typedef struct packed {
        logic sd;
        logic gpo;
        logic ph;
    } flags_t;
endpackage

// File: rtl/qcb_sync.sv
module qcb_sync #(
    parameter int   STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/qcb_decode.sv
module qcb_decode
    import qcb_pkg::*;
(
    input  logic          exec,
    input  logic [CW-1:0] word,
    input  logic          pd_en,
    output act_t          act
);
    logic [AW-1:0] addr;
    ctl_e          ctl;

    assign addr = word[CW-1 -: AW];
    assign ctl  = ctl_e'(word[DW+1:DW]);

    always_comb begin
        act      = '0;
        act.sel  = addr;
        act.data = word[DW-1:0];
        if (exec) begin
            unique case (ctl)
                CTL_STAGE: act.stage_wr = 1'b1;
                CTL_LOADUPD: begin
                    act.stage_wr = 1'b1;
                    act.copy_all = 1'b1;
                end
                CTL_SPECIAL: begin
                    unique case (addr)
                        2'd1: begin
                            act.copy_all = 1'b1;
                            act.sd_clr   = 1'b1;
                        end
                        2'd2: begin
                            act.bcast  = 1'b1;
                            act.sd_clr = 1'b1;
                        end
                        2'd3: act.sd_set = pd_en;
                        default: ;
                    endcase
                end
                CTL_MISC: begin
                    if (!addr[1]) begin
                        act.gpo_wr  = 1'b1;
                        act.gpo_val = addr[0];
                    end else begin
                        act.ph_wr    = 1'b1;
                        act.ph_val   = addr[0];
                        act.copy_all = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/quad_cmd_bank.sv
module quad_cmd_bank
    import qcb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       cmd_word,
    input  logic                cmd_exec,
    input  logic                load_n,
    input  logic                clr_n,
    input  logic                pd_en,
    output logic [NCH*DW-1:0]   chan_code,
    output logic                shutdown,
    output logic                gpo,
    output logic                phase_mode
);
    act_t   act;
    bank_t  bank_d, bank_q;
    flags_t flags_d, flags_q;
    logic   load_n_sync;
    logic   load_act;
    logic   bank_arst_n;
    logic [NCH*DW-1:0] in_flat;

    qcb_sync #(.STAGES(2), .RST_VAL(1'b1)) u_ldsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (load_n),
        .sync_o  (load_n_sync)
    );

    assign load_act = ~load_n_sync;

    qcb_decode u_dec (
        .exec  (cmd_exec),
        .word  (cmd_word),
        .pd_en (pd_en),
        .act   (act)
    );

    // channel registers: staging first, then outputs taken from next staging
    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NCH; i++) begin
            if (act.bcast || (act.stage_wr && act.sel == AW'(i)))
                bank_d.inr[i] = act.data;
        end
        for (int i = 0; i < NCH; i++) begin
            if (act.copy_all || act.bcast || load_act)
                bank_d.outr[i] = bank_d.inr[i];
        end
    end

    assign bank_arst_n = rst_n & clr_n;

    always_ff @(posedge clk or negedge bank_arst_n) begin
        if (!bank_arst_n) bank_q <= '0;
        else              bank_q <= bank_d;
    end

    // mode flags: untouched by the clear pin
    always_comb begin
        flags_d = flags_q;
        if (act.sd_set) flags_d.sd  = 1'b1;
        if (act.sd_clr) flags_d.sd  = 1'b0;
        if (act.gpo_wr) flags_d.gpo = act.gpo_val;
        if (act.ph_wr)  flags_d.ph  = act.ph_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign chan_code  = bank_q.outr;
    assign in_flat    = bank_q.inr;
    assign shutdown   = flags_q.sd;
    assign gpo        = flags_q.gpo;
    assign phase_mode = flags_q.ph;
endmodule

// File: rtl/qcb_checker.sv
module qcb_checker
    import qcb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              cmd_exec,
    input logic [CW-1:0]     cmd_word,
    input logic              pd_en,
    input logic              load_act,
    input logic [NCH*DW-1:0] in_flat,
    input logic [NCH*DW-1:0] chan_code,
    input logic              shutdown,
    input logic              gpo,
    input logic              phase_mode
);
    logic [3:0] op;
    assign op = cmd_word[CW-1 -: 4];

    // R2: a staging write leaves the outputs alone when the load pin is inactive
    a_r2_stage_hidden: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (cmd_exec && op[1:0] == 2'b01 && !load_act) |=> $stable(chan_code));

    // R3: load-and-update leaves outputs equal to staging
    a_r3_outputs_match: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (cmd_exec && op[1:0] == 2'b11) |=> (chan_code == in_flat));

    // R5: broadcast puts the data byte on every output
    a_r5_broadcast: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (cmd_exec && op == 4'b1000) |=> (chan_code == {NCH{$past(cmd_word[DW-1:0])}} && !shutdown));

    // R6: shutdown is refused without the enable
    a_r6_sd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_exec && op == 4'b1100 && !pd_en && !shutdown) |=> !shutdown);

    // R8: no-op changes nothing
    a_r8_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (cmd_exec && op == 4'b0000 && !load_act) |=>
        ($stable(chan_code) && $stable(shutdown) && $stable(gpo) && $stable(phase_mode)));

    // R9: phase mode changes only after a phase command
    a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_exec && op[1:0] == 2'b10 && op[3]) |=> $stable(phase_mode));

    // R10: with the load pin active the outputs track staging
    a_r10_transparent: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        load_act |=> (chan_code == in_flat));

    // R11: the clear pin holds every channel register at zero
    a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (chan_code == '0 && in_flat == '0));
endmodule

bind quad_cmd_bank qcb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .cmd_exec   (cmd_exec),
    .cmd_word   (cmd_word),
    .pd_en      (pd_en),
    .load_act   (load_act),
    .in_flat    (in_flat),
    .chan_code  (chan_code),
    .shutdown   (shutdown),
    .gpo        (gpo),
    .phase_mode (phase_mode)
);

// File: tb/tb_quad_cmd_bank.sv
module tb_quad_cmd_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cmd_word = '0;
    logic        cmd_exec = 1'b0;
    logic        load_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        pd_en = 1'b0;
    logic [31:0] chan_code;
    logic        shutdown, gpo, phase_mode;

    int vectors = 0;
    int misses  = 0;

    logic [7:0] m_in  [4];
    logic [7:0] m_out [4];
    logic       m_sd, m_gpo, m_ph, m_ld;

    always #2 clk = ~clk;

    quad_cmd_bank dut (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_exec(cmd_exec),
        .load_n(load_n), .clr_n(clr_n), .pd_en(pd_en), .chan_code(chan_code),
        .shutdown(shutdown), .gpo(gpo), .phase_mode(phase_mode)
    );

    task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 4; i++)
            cmp(req, $sformatf("ch%0d", i), chan_code[i*8 +: 8], m_out[i]);
        cmp(req, "shutdown", {7'd0, shutdown}, {7'd0, m_sd});
        cmp(req, "gpo", {7'd0, gpo}, {7'd0, m_gpo});
        cmp(req, "phase", {7'd0, phase_mode}, {7'd0, m_ph});
    endtask

    task automatic copy_model();
        for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op[1:0])
            2'b01: return "R2";
            2'b11: return "R3";
            2'b10: return op[3] ? "R9" : "R7";
            default: case (op[3:2])
                2'd0: return "R8";
                2'd1: return "R4";
                2'd2: return "R5";
                default: return "R6";
            endcase
        endcase
    endfunction

    // drive at a falling edge, execute on the next rising edge, check at the following falling edge
    task automatic do_cmd(input logic [11:0] w, input string req);
        logic [1:0] a;
        logic [7:0] d;
        a = w[11:10];
        d = w[7:0];
        @(negedge clk);
        cmd_word = w;
        cmd_exec = 1'b1;
        @(negedge clk);
        cmd_exec = 1'b0;
        case (w[9:8])
            2'b01: m_in[a] = d;
            2'b11: begin m_in[a] = d; copy_model(); end
            2'b10: begin
                if (!a[1]) m_gpo = a[0];
                else begin m_ph = a[0]; copy_model(); end
            end
            default: case (a)
                2'd1: begin copy_model(); m_sd = 1'b0; end
                2'd2: begin for (int i = 0; i < 4; i++) m_in[i] = d; copy_model(); m_sd = 1'b0; end
                2'd3: if (pd_en) m_sd = 1'b1;
                default: ;
            endcase
        endcase
        if (m_ld) copy_model();
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_out[i] = '0; end
        m_sd = 0; m_gpo = 0; m_ph = 0; m_ld = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11 reset");

        // R1: a word without the strobe does nothing
        cmd_word = 12'b10_11_0011_1100;
        repeat (2) @(negedge clk);
        check_all("R1 no strobe");

        // R1/R2: stage channel 2 only, hidden until a copy
        do_cmd(12'b10_01_0101_1010, "R2 stage ch2");
        do_cmd(12'b01_00_0000_0000, "R1 R4 copy ch2");
        cmp("R1", "ch2 slice", chan_code[23:16], 8'h5A);

        // R10: create a staging/output mismatch, then lower the load pin
        do_cmd(12'b00_01_0001_0001, "R2 stage ch0");
        load_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_all("R10 before sync delay");
        @(negedge clk);
        m_ld = 1'b1;
        copy_model();
        check_all("R10 after sync delay");
        load_n = 1'b1;
        repeat (3) @(negedge clk);
        m_ld = 1'b0;

        // sweep every command code with load inactive/active and enable low/high
        for (int lp = 0; lp < 2; lp++) begin
            if (lp == 1) begin
                load_n = 1'b0;
                repeat (3) @(negedge clk);
                m_ld = 1'b1;
                copy_model();
                check_all("R10 enter");
            end
            for (int pd = 0; pd < 2; pd++) begin
                pd_en = pd[0];
                for (int rnd = 0; rnd < 4; rnd++) begin
                    for (int op = 0; op < 16; op++) begin
                        logic [7:0] d;
                        d = 8'((op * 29 + rnd * 83 + pd * 7 + lp * 51 + 1) & 8'hFF);
                        do_cmd({4'(op), d}, lp ? "R10" : req_of(4'(op)));
                        if (op == 12) do_cmd({4'b1100, d}, req_of(4'b1100));
                    end
                end
            end
            if (lp == 1) begin
                load_n = 1'b1;
                repeat (3) @(negedge clk);
                m_ld = 1'b0;
            end
        end

        // R11: asynchronous clear between edges, flags kept
        do_cmd(12'b11_11_1100_0011, "R3 setup");
        do_cmd(12'b01_10_0000_0000, "R7 setup");
        do_cmd(12'b11_10_0000_0000, "R9 setup");
        do_cmd(12'b00_01_0111_0111, "R2 setup");
        @(negedge clk);
        #1 clr_n = 1'b0;
        #0.5;
        for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_out[i] = '0; end
        check_all("R11 async clear");
        @(negedge clk);
        clr_n = 1'b1;
        do_cmd(12'b01_00_0000_0000, "R11 staging cleared");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule